// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block is a small memory-mapped peripheral for a workstation's system controller. It holds the following registers:

- byte-wide configuration, diagnostic, modem-control and two auxiliary registers;
- a 16-bit diagnostic LED register;
- a 32-bit system-control register.

Around these registers sit the power-fail interrupt logic, a software power-off request, a software system-reset request and a CPU-idle strobe port. The bus is a plain synchronous register interface with no back-pressure. A read or write strobe is accepted in the cycle it is high and always completes. Read data appears in the following cycle.

The main window is found by the top address nibble. A 12-bit field (address bits 27:16) then selects a register inside it. The first auxiliary register, the second auxiliary register and the idle port each answer at one exact address of their own.

The second auxiliary register mixes three behaviours:

- a sticky power-fail status bit, set from the synchronized power-fail input;
- a write-one-to-clear bit for that status;
- a stored power-off bit, whose write raises a power-off request.

The interrupt is the status bit gated by an enable bit in the configuration register. Reset keeps the diagnostic, LED and system-control contents, so software can still read the reset status after a soft reset.

Top module: `sysctl_aux_top`

## Requirements
- R1: Address map. The main window hits when address bits 31:28 equal those of MAIN_BASE and bits 15:0 are zero. Bits 27:16 then select the register: 0x160 LED, 0x180 configuration, 0x1A0 diagnostic, 0x1B0 modem control, 0x1F0 system control. The first auxiliary register, the second auxiliary register and the idle port each hit only at their exact parameter address.
- R2: The interrupt output is a registered level. It is 1 exactly when status bit 5 of the second auxiliary register and enable bit 3 of the configuration register are both 1. It takes its new value on the same clock edge that updates either bit.
- R3: The power-fail input passes through SYNC_STAGES flip-flops. When the synchronized value changes, status bit 5 is loaded with (synchronized value AND configuration bit 3). At all other times bit 5 changes only through a write.
- R4: A byte write to the second auxiliary register behaves as follows:
  - it stores write bit 0;
  - it keeps the current bit 5, but clears it when write bit 1 is 1;
  - bit 1 is never stored, and every other bit reads 0.
- R5: A write to the second auxiliary register with data bit 0 = 1 gives a power-off request pulse. The stored bit 0 then reads 1.
- R6: A word write to the system-control register with bit 0 = 1 loads it with 0x2 and gives a system-reset request pulse. A word write with bit 0 = 0 changes nothing.
- R7: Reset clears configuration, modem control and both auxiliary registers. It leaves the diagnostic, LED and system-control registers unchanged.
- R8: Size codes are 0 = byte, 1 = halfword, 2 = word. Byte registers and the idle port need size 0, the LED register needs size 1 and the system-control register needs size 2. An access with any other size reads 0 and its write is ignored.
- R9: The LED register is read and written as a halfword at window offset 0. Offset 1 of that window reads 0.
- R10: Any byte write to the idle port gives a CPU-halt request pulse, whatever the data. Reads of the idle port return 0.
- R11: Reads from undecoded addresses return 0, and writes to them change no register.
- R12: Read data is registered. It is valid in the cycle after the read strobe and holds until the next read.
- R13: The power-off, system-reset and CPU-halt requests are each one clock wide. Each appears in the cycle after the triggering write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data, right-aligned |
| bus_rdata | output | 32 | Registered read data, right-aligned |
| pwr_fail_in | input | 1 | Asynchronous power-fail indication |
| pf_irq | output | 1 | Power-fail interrupt level |
| pwroff_req | output | 1 | Power-off request pulse |
| sysrst_req | output | 1 | System-reset request pulse |
| halt_req | output | 1 | CPU-halt request pulse |

## Verification
The bench builds the block with its default parameters:

- the main window at 0x7000_0000;
- the auxiliary registers at 0x8190_0000 and 0x8191_0000;
- the idle port at 0x8A00_0000;
- a two-stage synchronizer.

With aux addresses outside the main window's nibble, every decode path can be hit separately, including near-miss offsets and wrong access sizes. The two-stage synchronizer puts the status update three edges after the power-fail input changes, so the bench can also order power-fail edges against enable-bit and clear writes.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;

  typedef enum logic [3:0] {
    RG_NONE   = 4'd0,
    RG_CFG    = 4'd1,
    RG_DIAG   = 4'd2,
    RG_MODEM  = 4'd3,
    RG_LED    = 4'd4,
    RG_SYSCTL = 4'd5,
    RG_AUX1   = 4'd6,
    RG_AUX2   = 4'd7,
    RG_IDLE   = 4'd8
  } reg_sel_e;

  // window field codes (address bits 27:16)
  localparam logic [11:0] FLD_LED    = 12'h160;
  localparam logic [11:0] FLD_CFG    = 12'h180;
  localparam logic [11:0] FLD_DIAG   = 12'h1A0;
  localparam logic [11:0] FLD_MODEM  = 12'h1B0;
  localparam logic [11:0] FLD_SYSCTL = 12'h1F0;

  localparam int CFG_PFIE_BIT  = 3;
  localparam int AUX2_STAT_BIT = 5;
  localparam int AUX2_CLR_BIT  = 1;
  localparam int AUX2_OFF_BIT  = 0;
  localparam int SYS_GO_BIT    = 0;
  localparam logic [31:0] SYS_RST_STATUS = 32'h0000_0002;

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] MAIN_BASE = 32'h7000_0000,
  parameter logic [31:0] AUX1_ADDR = 32'h8190_0000,
  parameter logic [31:0] AUX2_ADDR = 32'h8191_0000,
  parameter logic [31:0] IDLE_ADDR = 32'h8A00_0000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output reg_sel_e          sel
);

  localparam int FLD_LSB = 16;
  localparam int FLD_MSB = 27;
  localparam int WIN_LSB = FLD_MSB + 1;

  logic        in_main;
  logic        low_zero;
  logic [11:0] field;
  reg_sel_e    raw_sel;
  acc_size_e   need_size;

  assign in_main  = (addr[ADDR_W-1:WIN_LSB] == MAIN_BASE[ADDR_W-1:WIN_LSB]);
  assign low_zero = (addr[FLD_LSB-1:0] == '0);
  assign field    = addr[FLD_MSB:FLD_LSB];

  always_comb begin
    raw_sel = RG_NONE;
    if (addr == AUX1_ADDR[ADDR_W-1:0])       raw_sel = RG_AUX1;
    else if (addr == AUX2_ADDR[ADDR_W-1:0])  raw_sel = RG_AUX2;
    else if (addr == IDLE_ADDR[ADDR_W-1:0])  raw_sel = RG_IDLE;
    else if (in_main && low_zero) begin
      unique case (field)
        FLD_LED:    raw_sel = RG_LED;
        FLD_CFG:    raw_sel = RG_CFG;
        FLD_DIAG:   raw_sel = RG_DIAG;
        FLD_MODEM:  raw_sel = RG_MODEM;
        FLD_SYSCTL: raw_sel = RG_SYSCTL;
        default:    raw_sel = RG_NONE;
      endcase
    end
  end

  always_comb begin
    unique case (raw_sel)
      RG_LED:    need_size = ACC_HALF;
      RG_SYSCTL: need_size = ACC_WORD;
      default:   need_size = ACC_BYTE;
    endcase
  end

  assign sel = (size == need_size) ? raw_sel : RG_NONE;

endmodule

// File: rtl/sysctl_pwrfail.sv
module sysctl_pwrfail
  import sysctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pf_async,
  input  logic       pfie_q,
  input  logic       pfie_d,
  input  logic       aux2_wr,
  input  logic [1:0] aux2_wbits,
  output logic [7:0] aux2_q,
  output logic       irq_o,
  output logic       pwroff_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   pf_s;
  logic                   pf_prev_q;
  logic                   pf_edge;
  logic                   stat_mid;
  logic [7:0]             aux2_d;
  logic                   irq_q;
  logic                   pwroff_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-2:0], pf_async};
  end

  assign pf_s    = chain_q[SYNC_STAGES-1];
  assign pf_edge = pf_s ^ pf_prev_q;

  // input change is applied before any same-cycle write
  assign stat_mid = pf_edge ? (pf_s & pfie_q) : aux2_q[AUX2_STAT_BIT];

  always_comb begin
    aux2_d = '0;
    if (aux2_wr) begin
      aux2_d[AUX2_OFF_BIT]  = aux2_wbits[AUX2_OFF_BIT];
      aux2_d[AUX2_STAT_BIT] = stat_mid & ~aux2_wbits[AUX2_CLR_BIT];
    end else begin
      aux2_d[AUX2_OFF_BIT]  = aux2_q[AUX2_OFF_BIT];
      aux2_d[AUX2_STAT_BIT] = stat_mid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pf_prev_q <= 1'b0;
      aux2_q    <= '0;
      irq_q     <= 1'b0;
      pwroff_q  <= 1'b0;
    end else begin
      pf_prev_q <= pf_s;
      aux2_q    <= aux2_d;
      irq_q     <= aux2_d[AUX2_STAT_BIT] & pfie_d;
      pwroff_q  <= aux2_wr & aux2_wbits[AUX2_OFF_BIT];
    end
  end

  assign irq_o    = irq_q;
  assign pwroff_o = pwroff_q;

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (aux2_q[AUX2_STAT_BIT] && pfie_q)); // R2

  AST_STAT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aux2_q[AUX2_STAT_BIT]) |-> $past(pfie_q)); // R3

  AST_AUX2_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (aux2_q & 8'hDE) == 8'h00); // R4

  AST_PWROFF_STORED: assert property (@(posedge clk) disable iff (!rst_n)
    pwroff_o |-> aux2_q[AUX2_OFF_BIT]); // R5

endmodule

// File: rtl/sysctl_regs.sv
module sysctl_regs
  import sysctl_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LED_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  reg_sel_e          sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic [7:0]        aux2_q,
  output logic [DATA_W-1:0] rdata,
  output logic              pfie_q,
  output logic              pfie_d,
  output logic              sysrst_o
);

  localparam int BYTE_PAD = DATA_W - 8;
  localparam int LED_PAD  = DATA_W - LED_W;

  logic [7:0]        cfg_q, diag_q, modem_q, aux1_q;
  logic [LED_W-1:0]  led_q;
  logic [DATA_W-1:0] sys_q;
  logic [DATA_W-1:0] rmux;
  logic [DATA_W-1:0] rdata_q;
  logic              sysrst_q;
  logic              sys_go;

  assign sys_go = wr && (sel == RG_SYSCTL) && wdata[SYS_GO_BIT];

  // registers cleared by reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q    <= '0;
      modem_q  <= '0;
      aux1_q   <= '0;
      sysrst_q <= 1'b0;
    end else begin
      if (wr && sel == RG_CFG)   cfg_q   <= wdata[7:0];
      if (wr && sel == RG_MODEM) modem_q <= wdata[7:0];
      if (wr && sel == RG_AUX1)  aux1_q  <= wdata[7:0];
      sysrst_q <= sys_go;
    end
  end

  // registers that survive reset
  always_ff @(posedge clk) begin
    if (wr && sel == RG_DIAG) diag_q <= wdata[7:0];
    if (wr && sel == RG_LED)  led_q  <= wdata[LED_W-1:0];
    if (sys_go)               sys_q  <= SYS_RST_STATUS;
  end

  assign pfie_q = cfg_q[CFG_PFIE_BIT];
  assign pfie_d = (wr && sel == RG_CFG) ? wdata[CFG_PFIE_BIT] : cfg_q[CFG_PFIE_BIT];

  always_comb begin
    unique case (sel)
      RG_CFG:    rmux = {{BYTE_PAD{1'b0}}, cfg_q};
      RG_DIAG:   rmux = {{BYTE_PAD{1'b0}}, diag_q};
      RG_MODEM:  rmux = {{BYTE_PAD{1'b0}}, modem_q};
      RG_AUX1:   rmux = {{BYTE_PAD{1'b0}}, aux1_q};
      RG_AUX2:   rmux = {{BYTE_PAD{1'b0}}, aux2_q};
      RG_LED:    rmux = {{LED_PAD{1'b0}}, led_q};
      RG_SYSCTL: rmux = sys_q;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata_q <= '0;
    else if (rd) rdata_q <= rmux;
  end

  assign rdata    = rdata_q;
  assign sysrst_o = sysrst_q;

  AST_SYSRST_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    sysrst_o |-> (sys_q == SYS_RST_STATUS)); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && sel == RG_CFG) |=> $stable(cfg_q)); // R8

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd |=> $stable(rdata)); // R12

endmodule

// File: rtl/sysctl_aux_top.sv
module sysctl_aux_top
  import sysctl_pkg::*;
#(
  parameter logic [31:0] MAIN_BASE   = 32'h7000_0000,
  parameter logic [31:0] AUX1_ADDR   = 32'h8190_0000,
  parameter logic [31:0] AUX2_ADDR   = 32'h8191_0000,
  parameter logic [31:0] IDLE_ADDR   = 32'h8A00_0000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic [1:0]  bus_size,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        pwr_fail_in,
  output logic        pf_irq,
  output logic        pwroff_req,
  output logic        sysrst_req,
  output logic        halt_req
);

  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int LED_W  = 16;

  reg_sel_e   sel;
  logic [7:0] aux2_q;
  logic       pfie_q, pfie_d;
  logic       halt_q;

  sysctl_decode #(
    .ADDR_W(ADDR_W), .MAIN_BASE(MAIN_BASE), .AUX1_ADDR(AUX1_ADDR),
    .AUX2_ADDR(AUX2_ADDR), .IDLE_ADDR(IDLE_ADDR)
  ) u_dec (
    .addr(bus_addr), .size(bus_size), .sel(sel)
  );

  sysctl_regs #(.DATA_W(DATA_W), .LED_W(LED_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .aux2_q(aux2_q), .rdata(bus_rdata),
    .pfie_q(pfie_q), .pfie_d(pfie_d), .sysrst_o(sysrst_req)
  );

  sysctl_pwrfail #(.SYNC_STAGES(SYNC_STAGES)) u_pf (
    .clk(clk), .rst_n(rst_n), .pf_async(pwr_fail_in),
    .pfie_q(pfie_q), .pfie_d(pfie_d),
    .aux2_wr(bus_wr && sel == RG_AUX2), .aux2_wbits(bus_wdata[1:0]),
    .aux2_q(aux2_q), .irq_o(pf_irq), .pwroff_o(pwroff_req)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= bus_wr && (sel == RG_IDLE);
  end

  assign halt_req = halt_q;

  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({halt_req, sysrst_req, pwroff_req}) <= 1); // R13

endmodule

// File: tb/sim_sysctl_aux_top.sv
module sim_sysctl_aux_top;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MAIN = 32'h7000_0000;
  localparam logic [31:0] A_LED  = MAIN | 32'h0160_0000;
  localparam logic [31:0] A_CFG  = MAIN | 32'h0180_0000;
  localparam logic [31:0] A_DIAG = MAIN | 32'h01A0_0000;
  localparam logic [31:0] A_MDM  = MAIN | 32'h01B0_0000;
  localparam logic [31:0] A_SYS  = MAIN | 32'h01F0_0000;
  localparam logic [31:0] A_AUX1 = 32'h8190_0000;
  localparam logic [31:0] A_AUX2 = 32'h8191_0000;
  localparam logic [31:0] A_IDLE = 32'h8A00_0000;
  localparam logic [1:0] SZB = 2'd0, SZH = 2'd1, SZW = 2'd2;

  logic clk = 0, rst_n = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0;
  logic [1:0]  bus_size = 0;
  logic bus_rd = 0, bus_wr = 0, pwr_fail_in = 0;
  logic [31:0] bus_rdata;
  logic pf_irq, pwroff_req, sysrst_req, halt_req;

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  logic seen_off, seen_rst, seen_halt;
  logic [31:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysctl_aux_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwr_fail_in(pwr_fail_in), .pf_irq(pf_irq),
    .pwroff_req(pwroff_req), .sysrst_req(sysrst_req), .halt_req(halt_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_wdata = d; bus_wr = 1;
    @(posedge clk); #1;
    seen_off = pwroff_req; seen_rst = sysrst_req; seen_halt = halt_req;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic bus_read(input logic [31:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_rd = 1;
    @(posedge clk); #1;
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 0;
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    wait_cycles(2);
    @(negedge clk); rst_n = 1;
  endtask

  task automatic t_reset_state();
    bus_read(A_CFG, SZB, rv);  chk("R7 cfg after reset", rv, 0);
    bus_read(A_AUX1, SZB, rv); chk("R7 aux1 after reset", rv, 0);
    bus_read(A_AUX2, SZB, rv); chk("R7 aux2 after reset", rv, 0);
    bus_read(A_MDM, SZB, rv);  chk("R7 modem after reset", rv, 0);
    chk("R2 irq after reset", {31'b0, pf_irq}, 0);
    chk("R13 no pulses after reset", {29'b0, pwroff_req, sysrst_req, halt_req}, 0);
  endtask

  task automatic t_byte_regs();
    bus_write(A_CFG, SZB, 32'h0000_00A5);
    bus_write(A_DIAG, SZB, 32'h0000_003C);
    bus_write(A_MDM, SZB, 32'h0000_0077);
    bus_write(A_AUX1, SZB, 32'hFFFF_FF81);
    bus_read(A_CFG, SZB, rv);  chk("R1 cfg readback", rv, 32'hA5);
    bus_read(A_DIAG, SZB, rv); chk("R1 diag readback", rv, 32'h3C);
    bus_read(A_MDM, SZB, rv);  chk("R1 modem readback", rv, 32'h77);
    bus_read(A_AUX1, SZB, rv); chk("R1 aux1 readback", rv, 32'h81);
  endtask

  task automatic t_read_hold();
    bus_read(A_MDM, SZB, rv);
    wait_cycles(3);
    chk("R12 rdata held", bus_rdata, 32'h77);
  endtask

  task automatic t_size_rules();
    bus_write(A_CFG, SZH, 32'h0000_0011);
    bus_read(A_CFG, SZB, rv); chk("R8 half write to cfg ignored", rv, 32'hA5);
    bus_read(A_CFG, SZW, rv); chk("R8 word read of cfg is 0", rv, 0);
    bus_write(A_SYS, SZH, 32'h1);
    chk("R8 half write to sysctl no reset pulse", {31'b0, seen_rst}, 0);
    bus_write(A_IDLE, SZW, 32'h0);
    chk("R8 word write to idle no halt", {31'b0, seen_halt}, 0);
  endtask

  task automatic t_led();
    bus_write(A_LED, SZH, 32'h1234_BEEF);
    bus_read(A_LED, SZH, rv); chk("R9 led readback", rv, 32'hBEEF);
    bus_write(A_LED, SZB, 32'h0000_0000);
    bus_read(A_LED, SZH, rv); chk("R8 byte write to led ignored", rv, 32'hBEEF);
    bus_read(A_LED | 32'h1, SZH, rv); chk("R9 led offset 1 reads 0", rv, 0);
  endtask

  task automatic t_undecoded();
    bus_write(MAIN | 32'h0170_0000, SZB, 32'h55);
    bus_read(MAIN | 32'h0170_0000, SZB, rv); chk("R11 undecoded read 0", rv, 0);
    bus_write(A_CFG | 32'h4, SZB, 32'h00);
    bus_read(A_CFG | 32'h4, SZB, rv); chk("R11 cfg+4 reads 0", rv, 0);
    bus_read(A_CFG, SZB, rv); chk("R11 cfg untouched by stray writes", rv, 32'hA5);
    bus_read(A_AUX1 | 32'h1, SZB, rv); chk("R1 aux1 exact address only", rv, 0);
  endtask

  task automatic t_pwrfail();
    bus_write(A_CFG, SZB, 32'h08);
    @(negedge clk); pwr_fail_in = 1;
    wait_cycles(4);
    chk("R2 irq raised with enable", {31'b0, pf_irq}, 1);
    bus_read(A_AUX2, SZB, rv); chk("R3 status bit set", rv, 32'h20);
    bus_write(A_CFG, SZB, 32'h00);
    chk("R2 irq drops with enable clear", {31'b0, pf_irq}, 0);
    bus_read(A_AUX2, SZB, rv); chk("R3 status kept on cfg write", rv, 32'h20);
    bus_write(A_CFG, SZB, 32'h08);
    chk("R2 irq returns with enable", {31'b0, pf_irq}, 1);
    bus_write(A_AUX2, SZB, 32'hFC);
    chk("R4 no poweroff on 0xFC", {31'b0, seen_off}, 0);
    bus_read(A_AUX2, SZB, rv); chk("R4 only status kept on 0xFC", rv, 32'h20);
    bus_write(A_AUX2, SZB, 32'h02);
    chk("R2 irq drops on clear", {31'b0, pf_irq}, 0);
    bus_read(A_AUX2, SZB, rv); chk("R4 write-one-clear", rv, 0);
    @(negedge clk); pwr_fail_in = 0;
    wait_cycles(4);
    bus_write(A_CFG, SZB, 32'h00);
    @(negedge clk); pwr_fail_in = 1;
    wait_cycles(4);
    bus_read(A_AUX2, SZB, rv); chk("R3 no status without enable", rv, 0);
    chk("R2 irq low without enable", {31'b0, pf_irq}, 0);
    @(negedge clk); pwr_fail_in = 0;
    wait_cycles(4);
  endtask

  task automatic t_poweroff();
    bus_write(A_AUX2, SZB, 32'h01);
    chk("R5 poweroff pulse", {31'b0, seen_off}, 1);
    wait_cycles(1);
    chk("R13 poweroff one cycle", {31'b0, pwroff_req}, 0);
    bus_read(A_AUX2, SZB, rv); chk("R5 stored off bit", rv, 32'h01);
  endtask

  task automatic t_sysctl();
    bus_write(A_SYS, SZW, 32'h0);
    chk("R6 no reset pulse for bit0=0", {31'b0, seen_rst}, 0);
    bus_write(A_SYS, SZW, 32'hFFFF_FFFF);
    chk("R6 reset pulse", {31'b0, seen_rst}, 1);
    wait_cycles(1);
    chk("R13 reset pulse one cycle", {31'b0, sysrst_req}, 0);
    bus_read(A_SYS, SZW, rv); chk("R6 status value", rv, 32'h2);
    bus_write(A_SYS, SZW, 32'h0);
    bus_read(A_SYS, SZW, rv); chk("R6 bit0=0 write no change", rv, 32'h2);
    bus_read(A_SYS | 32'h2, SZW, rv); chk("R11 sysctl offset 2 reads 0", rv, 0);
  endtask

  task automatic t_idle();
    bus_write(A_IDLE, SZB, 32'h0);
    chk("R10 halt pulse", {31'b0, seen_halt}, 1);
    wait_cycles(1);
    chk("R13 halt one cycle", {31'b0, halt_req}, 0);
    bus_write(A_IDLE, SZB, 32'hA7);
    chk("R10 halt any data", {31'b0, seen_halt}, 1);
    bus_read(A_IDLE, SZB, rv); chk("R10 idle reads 0", rv, 0);
  endtask

  task automatic t_reset_keep();
    bus_write(A_CFG, SZB, 32'h5A);
    bus_write(A_MDM, SZB, 32'h33);
    do_reset();
    bus_read(A_DIAG, SZB, rv); chk("R7 diag survives reset", rv, 32'h3C);
    bus_read(A_LED, SZH, rv);  chk("R7 led survives reset", rv, 32'hBEEF);
    bus_read(A_SYS, SZW, rv);  chk("R7 sysctl survives reset", rv, 32'h2);
    bus_read(A_CFG, SZB, rv);  chk("R7 cfg cleared", rv, 0);
    bus_read(A_MDM, SZB, rv);  chk("R7 modem cleared", rv, 0);
    bus_read(A_AUX1, SZB, rv); chk("R7 aux1 cleared", rv, 0);
    bus_read(A_AUX2, SZB, rv); chk("R7 aux2 cleared", rv, 0);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_byte_regs();
    t_read_hold();
    t_size_rules();
    t_led();
    t_undecoded();
    t_pwrfail();
    t_poweroff();
    t_sysctl();
    t_idle();
    t_reset_keep();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule